// File: doc/BRIEF.md
# USB endpoint buffer handshake controller

This block decides who owns each endpoint packet buffer in a USB device controller: the serial engine or the local processor. Every endpoint slot keeps an enable flag, a direction, a full flag, a packet length, an interrupt flag and, on the control pair, a setup lock. The buffers themselves live in a byte array inside the block. The engine fills OUT buffers and drains IN buffers through byte ports. It reports finished transactions with single-cycle strobes, and for each strobe it receives a registered ACK or NAK.

The processor uses a one-byte command port. It selects a slot, then reads status (which clears that slot's interrupt), reads or writes length and data through an auto-incrementing byte pointer, releases an OUT buffer, hands an IN buffer to the engine, configures the slot, or acknowledges a setup packet. Slot 0 is the control OUT endpoint and slot 1 the control IN endpoint. Both are always enabled and have fixed directions. A setup packet on slot 0 flushes slot 1 and freezes buffer release on both until each is acknowledged.

Top module: `usbep_handshake_ctrl`

## Requirements
- R1: After `rst` or a `bus_rst` pulse, every interrupt, full flag and setup lock is 0. Slots 2 and up are disabled with direction OUT. Slots 0 and 1 report enabled, and slot 1 reports direction IN.
- R2: An `eng_rx_stb` on an enabled, OUT-direction, empty slot gets `eng_ack` in the next cycle. The slot becomes full, takes `eng_rx_len` as its length and raises its bit in `ep_irq`. Bytes written earlier with `eng_wr_stb` become the buffer contents.
- R3: A receive strobe is answered with `eng_nak` and changes no state in these cases: the slot is already full, the slot is disabled, the slot is configured IN, or a setup strobe names any slot other than 0. Byte writes the engine makes to a full buffer are dropped.
- R4: Command STATUS (op 1) returns, in the next cycle on `cpu_rdata`, the byte {2'b00, irq, lock, setup, dir_in, enabled, full} (bit 0 = full) of the selected slot, and clears its interrupt. An engine event that sets the same interrupt in the same cycle wins. `irq_any` is the OR of all interrupts.
- R5: SELECT (op 0, slot number in `cpu_wdata[3:0]`) and RD_LEN (op 2) reset the byte pointer. RD_LEN returns the length. Each RD_BYTE (op 3) returns the next buffer byte one cycle later.
- R6: CLEAR (op 6) on a full OUT slot empties it and clears its setup flag, so the next receive is accepted.
- R7: On an IN slot, WR_LEN (op 4) and WR_BYTE (op 5) fill an empty buffer. Until VALIDATE (op 7), a transmit request (`eng_tx_stb`) is answered with NAK. After VALIDATE it is answered with ACK and with the length on `eng_tx_len`, and `eng_rd_data` shows the written bytes. `eng_done_stb` then empties the slot and raises its interrupt.
- R8: A setup strobe on slot 0 is always accepted, even if slot 0 is full. It sets slot 0 full, with the setup and lock flags set, flushes slot 1 to empty, and locks slot 1.
- R9: While a control slot is locked, CLEAR and VALIDATE on it are ignored. Slot 0 stays full and slot 1 stays empty.
- R10: ACK_SETUP (op 8) removes the lock only on the selected control slot. The other control slot stays locked.
- R11: CONFIG (op 9; `cpu_wdata[0]` = enable, `cpu_wdata[1]` = direction IN) on slots 2 and up is stored at any time. Its enable counts only while `enumerated` is 1. CONFIG on slots 0 and 1 has no effect.
- R12: Every receive or transmit strobe gets exactly one of `eng_ack`/`eng_nak`, in the following cycle only. When both strobes arrive in the same cycle, the receive strobe is answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rst | input | 1 | USB bus reset seen by the engine, one-cycle pulse |
| enumerated | input | 1 | Device configured by the host; gates slot enables 2 and up |
| cpu_stb | input | 1 | Processor command strobe |
| cpu_op | input | 4 | Command code |
| cpu_wdata | input | 8 | Command operand or data byte |
| cpu_rdata | output | 8 | Registered command response |
| ep_irq | output | 16 | Per-slot interrupt flags |
| irq_any | output | 1 | OR of all interrupt flags |
| eng_wr_stb | input | 1 | Engine writes one receive byte |
| eng_wr_setup | input | 1 | The byte belongs to a setup packet |
| eng_wr_ep | input | 4 | Slot of the byte write |
| eng_wr_ofs | input | 6 | Byte offset in the buffer |
| eng_wr_data | input | 8 | Byte value |
| eng_rx_stb | input | 1 | Engine received a packet |
| eng_rx_setup | input | 1 | The packet is a setup packet |
| eng_rx_ep | input | 4 | Slot of the packet |
| eng_rx_len | input | 7 | Byte count of the packet |
| eng_tx_stb | input | 1 | Engine asks whether a slot has data to send |
| eng_tx_ep | input | 4 | Slot asked |
| eng_done_stb | input | 1 | Engine finished sending a packet |
| eng_done_ep | input | 4 | Slot that was sent |
| eng_rd_ep | input | 4 | Slot of the transmit byte read |
| eng_rd_ofs | input | 6 | Offset of the transmit byte read |
| eng_rd_data | output | 8 | Combinational transmit byte |
| eng_ack | output | 1 | Strobe accepted |
| eng_nak | output | 1 | Strobe refused |
| eng_tx_len | output | 7 | Length of the accepted transmit buffer |

## Verification
The assertions check the following on every cycle:
- The engine handshake always gives exactly one answer, and only after a strobe.
- A setup packet is always taken.
- A bus reset leaves no interrupt, full flag or lock behind.
- A status read clears the selected interrupt.
- The control pair stays consistent while locked: slot 0 is held full and slot 1 is held empty.

Only the bench scenarios can show the data path and the ordering rules. These include byte contents after receive and write, and lengths returned to both sides. They also include the ignored CLEAR/VALIDATE under lock, the one-sided unlock, the enumeration gate, and the interrupt that wins over a same-cycle status read.

// File: rtl/usbep_pkg.sv
package usbep_pkg;

    localparam int unsigned MAX_PKT  = 64;
    localparam int unsigned LEN_W    = $clog2(MAX_PKT + 1);
    localparam int unsigned OFS_W    = $clog2(MAX_PKT);
    localparam int unsigned CTRL_OUT = 0;
    localparam int unsigned CTRL_IN  = 1;

    typedef enum logic [3:0] {
        OP_SELECT    = 4'd0,
        OP_STATUS    = 4'd1,
        OP_RD_LEN    = 4'd2,
        OP_RD_BYTE   = 4'd3,
        OP_WR_LEN    = 4'd4,
        OP_WR_BYTE   = 4'd5,
        OP_CLEAR     = 4'd6,
        OP_VALIDATE  = 4'd7,
        OP_ACK_SETUP = 4'd8,
        OP_CONFIG    = 4'd9
    } cpu_op_e;

    // Field order is the status byte layout, MSB first.
    typedef struct packed {
        logic irq;
        logic lock;
        logic setup;
        logic dir_in;
        logic en;
        logic full;
    } ep_flags_t;

    typedef struct packed {
        ep_flags_t        f;
        logic [LEN_W-1:0] len;
    } ep_state_t;

    // Per-slot update requests computed by the top level.
    typedef struct packed {
        logic             cfg_wr;
        logic             cfg_en;
        logic             cfg_dir;
        logic             rx_ok;
        logic             rx_setup;
        logic [LEN_W-1:0] rx_len;
        logic             tx_done;
        logic             flush;
        logic             lock_set;
        logic             clr;
        logic             val;
        logic             ack;
        logic             irq_clr;
        logic             len_wr;
        logic [LEN_W-1:0] len_val;
    } ep_ctl_t;

    function automatic logic [7:0] status_byte(ep_flags_t f);
        return {2'b00, f};
    endfunction

endpackage

// File: rtl/usbep_buf_ram.sv
module usbep_buf_ram #(
    parameter int unsigned DEPTH = 1024,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          a_we,
    input  logic          a_re,
    input  logic [AW-1:0] a_addr,
    input  logic [7:0]    a_wdata,
    output logic [7:0]    a_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_waddr,
    input  logic [7:0]    b_wdata,
    input  logic [AW-1:0] b_raddr,
    output logic [7:0]    b_rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (a_we) mem[a_addr] <= a_wdata;
        if (b_we) mem[b_waddr] <= b_wdata;
        if (a_re) a_rdata <= mem[a_addr];
    end

    assign b_rdata = mem[b_raddr];

endmodule

// File: rtl/usbep_ep_slot.sv
module usbep_ep_slot
    import usbep_pkg::*;
#(
    parameter bit IS_CTRL     = 1'b0,
    parameter bit CTRL_DIR_IN = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_rst,
    input  logic      enumerated,
    input  ep_ctl_t   ctl,
    output ep_state_t state
);
    logic             en_q, dir_q, full_q, irq_q, setup_q, lock_q;
    logic [LEN_W-1:0] len_q;
    logic             dir_eff;

    assign dir_eff = IS_CTRL ? CTRL_DIR_IN : dir_q;

    // Later statements take priority: engine events over processor commands,
    // setup lock over acknowledge, setup flush over validate.
    always_ff @(posedge clk) begin
        if (rst || bus_rst) begin
            en_q    <= 1'b0;
            dir_q   <= 1'b0;
            full_q  <= 1'b0;
            irq_q   <= 1'b0;
            setup_q <= 1'b0;
            lock_q  <= 1'b0;
            len_q   <= '0;
        end else begin
            if (ctl.irq_clr) irq_q <= 1'b0;
            if (ctl.cfg_wr && !IS_CTRL) begin
                en_q  <= ctl.cfg_en;
                dir_q <= ctl.cfg_dir;
            end
            if (ctl.clr && !lock_q && !dir_eff) begin
                full_q  <= 1'b0;
                setup_q <= 1'b0;
            end
            if (ctl.val && !lock_q && dir_eff) full_q <= 1'b1;
            if (ctl.len_wr && dir_eff && !full_q) len_q <= ctl.len_val;
            if (ctl.tx_done && dir_eff && full_q) begin
                full_q <= 1'b0;
                irq_q  <= 1'b1;
            end
            if (ctl.ack) lock_q <= 1'b0;
            if (ctl.rx_ok) begin
                full_q  <= 1'b1;
                irq_q   <= 1'b1;
                setup_q <= ctl.rx_setup;
                len_q   <= ctl.rx_len;
            end
            if (ctl.lock_set) lock_q <= 1'b1;
            if (ctl.flush) full_q <= 1'b0;
        end
    end

    assign state.f.irq    = irq_q;
    assign state.f.lock   = lock_q;
    assign state.f.setup  = setup_q;
    assign state.f.dir_in = dir_eff;
    assign state.f.en     = IS_CTRL ? 1'b1 : (en_q & enumerated);
    assign state.f.full   = full_q;
    assign state.len      = len_q;

endmodule

// File: rtl/usbep_handshake_ctrl.sv
module usbep_handshake_ctrl
    import usbep_pkg::*;
#(
    parameter int unsigned NUM_EP = 16,
    localparam int unsigned EP_W  = $clog2(NUM_EP),
    localparam int unsigned DEPTH = NUM_EP * MAX_PKT,
    localparam int unsigned AW    = EP_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rst,
    input  logic              enumerated,
    input  logic              cpu_stb,
    input  logic [3:0]        cpu_op,
    input  logic [7:0]        cpu_wdata,
    output logic [7:0]        cpu_rdata,
    output logic [NUM_EP-1:0] ep_irq,
    output logic              irq_any,
    input  logic              eng_wr_stb,
    input  logic              eng_wr_setup,
    input  logic [EP_W-1:0]   eng_wr_ep,
    input  logic [OFS_W-1:0]  eng_wr_ofs,
    input  logic [7:0]        eng_wr_data,
    input  logic              eng_rx_stb,
    input  logic              eng_rx_setup,
    input  logic [EP_W-1:0]   eng_rx_ep,
    input  logic [LEN_W-1:0]  eng_rx_len,
    input  logic              eng_tx_stb,
    input  logic [EP_W-1:0]   eng_tx_ep,
    input  logic              eng_done_stb,
    input  logic [EP_W-1:0]   eng_done_ep,
    input  logic [EP_W-1:0]   eng_rd_ep,
    input  logic [OFS_W-1:0]  eng_rd_ofs,
    output logic [7:0]        eng_rd_data,
    output logic              eng_ack,
    output logic              eng_nak,
    output logic [LEN_W-1:0]  eng_tx_len
);
    cpu_op_e          op;
    logic [EP_W-1:0]  sel_q;
    logic [OFS_W-1:0] ptr_q;
    logic [7:0]       rsp_q, ram_q;
    logic             rsp_ram_q;
    ep_state_t        st [NUM_EP];
    ep_ctl_t          ctl [NUM_EP];
    ep_state_t        cur, rxs, wrs, txs;
    logic [NUM_EP-1:0] full_v, lock_v;
    logic             setup_hit, data_hit, rx_take, tx_ok, eng_we, cpu_we;

    assign op  = cpu_op_e'(cpu_op);
    assign cur = st[sel_q];
    assign rxs = st[eng_rx_ep];
    assign wrs = st[eng_wr_ep];
    assign txs = st[eng_tx_ep];

    // Engine side acceptance.
    assign setup_hit = eng_rx_stb && eng_rx_setup && (eng_rx_ep == EP_W'(CTRL_OUT));
    assign data_hit  = eng_rx_stb && !eng_rx_setup && rxs.f.en && !rxs.f.dir_in && !rxs.f.full;
    assign rx_take   = setup_hit || data_hit;
    assign tx_ok     = eng_tx_stb && txs.f.en && txs.f.dir_in && txs.f.full;
    assign eng_we    = eng_wr_stb &&
                       ((eng_wr_setup && eng_wr_ep == EP_W'(CTRL_OUT)) ||
                        (!eng_wr_setup && wrs.f.en && !wrs.f.dir_in && !wrs.f.full));
    assign cpu_we    = cpu_stb && op == OP_WR_BYTE && cur.f.dir_in && !cur.f.full;

    always_comb begin
        for (int e = 0; e < NUM_EP; e++) begin
            logic hit;
            hit = (sel_q == EP_W'(e)) && cpu_stb;
            ctl[e]          = '0;
            ctl[e].cfg_wr   = hit && op == OP_CONFIG;
            ctl[e].cfg_en   = cpu_wdata[0];
            ctl[e].cfg_dir  = cpu_wdata[1];
            ctl[e].rx_ok    = rx_take && eng_rx_ep == EP_W'(e);
            ctl[e].rx_setup = eng_rx_setup;
            ctl[e].rx_len   = eng_rx_len;
            ctl[e].tx_done  = eng_done_stb && eng_done_ep == EP_W'(e);
            ctl[e].flush    = setup_hit && e == CTRL_IN;
            ctl[e].lock_set = setup_hit && (e == CTRL_OUT || e == CTRL_IN);
            ctl[e].clr      = hit && op == OP_CLEAR;
            ctl[e].val      = hit && op == OP_VALIDATE;
            ctl[e].ack      = hit && op == OP_ACK_SETUP;
            ctl[e].irq_clr  = hit && op == OP_STATUS;
            ctl[e].len_wr   = hit && op == OP_WR_LEN;
            ctl[e].len_val  = cpu_wdata[LEN_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
        usbep_ep_slot #(
            .IS_CTRL    (g == CTRL_OUT || g == CTRL_IN),
            .CTRL_DIR_IN(g == CTRL_IN)
        ) i_slot (
            .clk       (clk),
            .rst       (rst),
            .bus_rst   (bus_rst),
            .enumerated(enumerated),
            .ctl       (ctl[g]),
            .state     (st[g])
        );
        assign ep_irq[g] = st[g].f.irq;
        assign full_v[g] = st[g].f.full;
        assign lock_v[g] = st[g].f.lock;
    end

    assign irq_any = |ep_irq;

    usbep_buf_ram #(.DEPTH(DEPTH)) i_ram (
        .clk    (clk),
        .a_we   (cpu_we),
        .a_re   (cpu_stb && op == OP_RD_BYTE),
        .a_addr ({sel_q, ptr_q}),
        .a_wdata(cpu_wdata),
        .a_rdata(ram_q),
        .b_we   (eng_we),
        .b_waddr({eng_wr_ep, eng_wr_ofs}),
        .b_wdata(eng_wr_data),
        .b_raddr({eng_rd_ep, eng_rd_ofs}),
        .b_rdata(eng_rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            ptr_q      <= '0;
            rsp_q      <= '0;
            rsp_ram_q  <= 1'b0;
            eng_ack    <= 1'b0;
            eng_nak    <= 1'b0;
            eng_tx_len <= '0;
        end else begin
            eng_ack <= rx_take || (!eng_rx_stb && tx_ok);
            eng_nak <= (eng_rx_stb && !rx_take) || (!eng_rx_stb && eng_tx_stb && !tx_ok);
            if (!eng_rx_stb && tx_ok) eng_tx_len <= txs.len;
            if (cpu_stb) begin
                unique case (op)
                    OP_SELECT: begin
                        sel_q <= cpu_wdata[EP_W-1:0];
                        ptr_q <= '0;
                    end
                    OP_STATUS: begin
                        rsp_q     <= status_byte(cur.f);
                        rsp_ram_q <= 1'b0;
                    end
                    OP_RD_LEN: begin
                        rsp_q     <= 8'(cur.len);
                        rsp_ram_q <= 1'b0;
                        ptr_q     <= '0;
                    end
                    OP_RD_BYTE: begin
                        rsp_ram_q <= 1'b1;
                        ptr_q     <= ptr_q + 1'b1;
                    end
                    OP_WR_LEN:  ptr_q <= '0;
                    OP_WR_BYTE: if (cpu_we) ptr_q <= ptr_q + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign cpu_rdata = rsp_ram_q ? ram_q : rsp_q;

endmodule

// File: rtl/usbep_handshake_chk.sv
module usbep_handshake_chk
    import usbep_pkg::*;
#(
    parameter int unsigned NUM_EP = 16,
    localparam int unsigned EP_W  = $clog2(NUM_EP)
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_rst,
    input logic              cpu_stb,
    input logic [3:0]        cpu_op,
    input logic [EP_W-1:0]   sel_q,
    input logic [NUM_EP-1:0] full_v,
    input logic [NUM_EP-1:0] lock_v,
    input logic [NUM_EP-1:0] ep_irq,
    input logic              eng_rx_stb,
    input logic              eng_rx_setup,
    input logic [EP_W-1:0]   eng_rx_ep,
    input logic              eng_tx_stb,
    input logic              eng_done_stb,
    input logic              eng_ack,
    input logic              eng_nak
);
    p_ack_nak_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(eng_ack && eng_nak));

    p_answered_r12: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_stb || eng_tx_stb) |=> (eng_ack || eng_nak));

    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !(eng_rx_stb || eng_tx_stb) |=> !(eng_ack || eng_nak));

    p_setup_taken_r8: assert property (@(posedge clk) disable iff (rst)
        (eng_rx_stb && eng_rx_setup && eng_rx_ep == '0) |=> eng_ack);

    p_bus_reset_r1: assert property (@(posedge clk) disable iff (rst)
        bus_rst |=> (ep_irq == '0 && full_v == '0 && lock_v == '0));

    p_status_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (cpu_stb && cpu_op == 4'(OP_STATUS) && !eng_rx_stb && !eng_done_stb)
        |=> !ep_irq[$past(sel_q)]);

    p_locked_out_held_r9: assert property (@(posedge clk) disable iff (rst)
        lock_v[0] |-> full_v[0]);

    p_locked_in_empty_r9: assert property (@(posedge clk) disable iff (rst)
        lock_v[1] |-> !full_v[1]);

endmodule

bind usbep_handshake_ctrl usbep_handshake_chk #(.NUM_EP(NUM_EP)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_rst     (bus_rst),
    .cpu_stb     (cpu_stb),
    .cpu_op      (cpu_op),
    .sel_q       (sel_q),
    .full_v      (full_v),
    .lock_v      (lock_v),
    .ep_irq      (ep_irq),
    .eng_rx_stb  (eng_rx_stb),
    .eng_rx_setup(eng_rx_setup),
    .eng_rx_ep   (eng_rx_ep),
    .eng_tx_stb  (eng_tx_stb),
    .eng_done_stb(eng_done_stb),
    .eng_ack     (eng_ack),
    .eng_nak     (eng_nak)
);

// File: tb/test_usbep_handshake_ctrl.sv
module test_usbep_handshake_ctrl;
    localparam int NEP = 16;

    logic        clk = 1'b0, rst = 1'b1, bus_rst = 1'b0, enumerated = 1'b0;
    logic        cpu_stb = 1'b0;
    logic [3:0]  cpu_op = '0;
    logic [7:0]  cpu_wdata = '0, cpu_rdata;
    logic [NEP-1:0] ep_irq;
    logic        irq_any;
    logic        eng_wr_stb = 1'b0, eng_wr_setup = 1'b0;
    logic [3:0]  eng_wr_ep = '0;
    logic [5:0]  eng_wr_ofs = '0;
    logic [7:0]  eng_wr_data = '0;
    logic        eng_rx_stb = 1'b0, eng_rx_setup = 1'b0;
    logic [3:0]  eng_rx_ep = '0;
    logic [6:0]  eng_rx_len = '0;
    logic        eng_tx_stb = 1'b0;
    logic [3:0]  eng_tx_ep = '0;
    logic        eng_done_stb = 1'b0;
    logic [3:0]  eng_done_ep = '0;
    logic [3:0]  eng_rd_ep = '0;
    logic [5:0]  eng_rd_ofs = '0;
    logic [7:0]  eng_rd_data;
    logic        eng_ack, eng_nak;
    logic [6:0]  eng_tx_len;

    int n_run = 0, n_fail = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    usbep_handshake_ctrl #(.NUM_EP(NEP)) i_usbep_handshake_ctrl (
        .clk(clk), .rst(rst), .bus_rst(bus_rst), .enumerated(enumerated),
        .cpu_stb(cpu_stb), .cpu_op(cpu_op), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .ep_irq(ep_irq), .irq_any(irq_any),
        .eng_wr_stb(eng_wr_stb), .eng_wr_setup(eng_wr_setup), .eng_wr_ep(eng_wr_ep),
        .eng_wr_ofs(eng_wr_ofs), .eng_wr_data(eng_wr_data),
        .eng_rx_stb(eng_rx_stb), .eng_rx_setup(eng_rx_setup), .eng_rx_ep(eng_rx_ep),
        .eng_rx_len(eng_rx_len), .eng_tx_stb(eng_tx_stb), .eng_tx_ep(eng_tx_ep),
        .eng_done_stb(eng_done_stb), .eng_done_ep(eng_done_ep),
        .eng_rd_ep(eng_rd_ep), .eng_rd_ofs(eng_rd_ofs), .eng_rd_data(eng_rd_data),
        .eng_ack(eng_ack), .eng_nak(eng_nak), .eng_tx_len(eng_tx_len)
    );

    localparam logic [3:0] SEL = 0, STAT = 1, RDL = 2, RDB = 3, WRL = 4, WRB = 5,
                           CLR = 6, VAL = 7, ACKS = 8, CFG = 9;

    function automatic logic [7:0] pat(int e, int i, int s);
        return 8'((e * 29 + i * 7 + s * 13 + 1) & 255);
    endfunction

    // {irq, lock, setup, dir_in, en, full}
    function automatic int xs(int full, int en, int dir, int setup, int lock, int irq);
        return irq * 32 + lock * 16 + setup * 8 + dir * 4 + en * 2 + full;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cpu(input logic [3:0] op, input int wd);
        @(negedge clk);
        cpu_stb = 1'b1; cpu_op = op; cpu_wdata = 8'(wd);
        @(negedge clk);
        cpu_stb = 1'b0;
    endtask

    task automatic status(input int e, output int s);
        cpu(SEL, e);
        cpu(STAT, 0);
        s = int'(cpu_rdata);
    endtask

    // Handshake result: 2 = ack, 1 = nak; also checks the quiet cycle after (R12).
    task automatic hs_check(string req, int exp);
        chk(req, {eng_ack, eng_nak}, exp);
        @(negedge clk);
        chk("R12 quiet", {eng_ack, eng_nak}, 0);
    endtask

    task automatic rx(input int e, input int len, input int setup, input int seed, output int hs);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            eng_wr_stb = 1'b1; eng_wr_setup = setup[0]; eng_wr_ep = 4'(e);
            eng_wr_ofs = 6'(i); eng_wr_data = pat(e, i, seed);
        end
        @(negedge clk);
        eng_wr_stb = 1'b0;
        eng_rx_stb = 1'b1; eng_rx_setup = setup[0]; eng_rx_ep = 4'(e); eng_rx_len = 7'(len);
        @(negedge clk);
        eng_rx_stb = 1'b0;
        hs = {eng_ack, eng_nak};
    endtask

    task automatic txq(input int e, output int hs, output int len);
        @(negedge clk);
        eng_tx_stb = 1'b1; eng_tx_ep = 4'(e);
        @(negedge clk);
        eng_tx_stb = 1'b0;
        hs = {eng_ack, eng_nak};
        len = int'(eng_tx_len);
    endtask

    task automatic sent(input int e);
        @(negedge clk);
        eng_done_stb = 1'b1; eng_done_ep = 4'(e);
        @(negedge clk);
        eng_done_stb = 1'b0;
    endtask

    task automatic summary();
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int s, hs, ln;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every slot
        chk("R1 irq", int'(ep_irq), 0);
        chk("R1 handshake", {eng_ack, eng_nak}, 0);
        for (int e = 0; e < NEP; e++) begin
            status(e, s);
            chk($sformatf("R1 status ep%0d", e), s, xs(0, e < 2, e == 1, 0, 0, 0));
        end

        // R11: configuration before enumeration (even OUT, odd IN)
        for (int e = 2; e < NEP; e++) begin
            cpu(SEL, e);
            cpu(CFG, (e % 2) ? 3 : 1);
        end
        rx(2, 4, 0, 0, hs);
        hs_check("R11 rx before enumeration nak", 1);
        status(2, s);
        chk("R11 gated enable", s, xs(0, 0, 0, 0, 0, 0));
        enumerated = 1'b1;
        status(3, s);
        chk("R11 enable after enumeration", s, xs(0, 1, 1, 0, 0, 0));

        // R2/R3/R4/R5/R6: sweep over every OUT slot
        for (int e = 0; e < NEP; e += 2) begin
            int len = e + 3;
            rx(e, len, 0, 1, hs);
            hs_check($sformatf("R2 rx ack ep%0d", e), 2);
            chk("R2 irq bit", int'(ep_irq[e]), 1);
            status(e, s);
            chk("R4 status full+irq", s, xs(1, 1, 0, 0, 0, 1));
            cpu(STAT, 0);
            chk("R4 irq cleared by read", int'(cpu_rdata), xs(1, 1, 0, 0, 0, 0));
            rx(e, len, 0, 9, hs);
            hs_check("R3 rx to full nak", 1);
            cpu(RDL, 0);
            chk("R5 length", int'(cpu_rdata), len);
            for (int i = 0; i < len; i++) begin
                cpu(RDB, 0);
                chk($sformatf("R5 byte ep%0d[%0d]", e, i), int'(cpu_rdata), int'(pat(e, i, 1)));
            end
            cpu(CLR, 0);
            cpu(STAT, 0);
            chk("R6 cleared", int'(cpu_rdata), xs(0, 1, 0, 0, 0, 0));
            rx(e, 2, 0, 2, hs);
            hs_check("R6 accepts again", 2);
            cpu(CLR, 0);
            cpu(STAT, 0);
        end

        // R7: sweep over every IN slot
        for (int e = 1; e < NEP; e += 2) begin
            int len = e + 1;
            txq(e, hs, ln);
            hs_check($sformatf("R7 nak before validate ep%0d", e), 1);
            cpu(SEL, e);
            cpu(WRL, len);
            for (int i = 0; i < len; i++) cpu(WRB, pat(e, i, 7));
            cpu(VAL, 0);
            txq(e, hs, ln);
            chk("R7 tx length", ln, len);
            hs_check("R7 ack after validate", 2);
            for (int i = 0; i < len; i++) begin
                @(negedge clk);
                eng_rd_ep = 4'(e); eng_rd_ofs = 6'(i);
                #1;
                chk($sformatf("R7 tx byte ep%0d[%0d]", e, i), int'(eng_rd_data), int'(pat(e, i, 7)));
            end
            sent(e);
            chk("R7 irq after send", int'(ep_irq[e]), 1);
            status(e, s);
            chk("R7 status after send", s, xs(0, 1, 1, 0, 0, 1));
            txq(e, hs, ln);
            hs_check("R7 nak after send", 1);
        end

        // R3: wrong direction and misplaced setup
        rx(3, 2, 0, 0, hs);
        hs_check("R3 rx on IN slot nak", 1);
        rx(5, 2, 1, 0, hs);
        hs_check("R3 setup on slot 5 nak", 1);

        // R8/R9/R10: setup locking of the control pair
        rx(0, 4, 0, 3, hs);
        hs_check("R2 ctrl data ack", 2);
        cpu(SEL, 1);
        cpu(WRL, 2);
        cpu(WRB, 8'hA1);
        cpu(WRB, 8'hA2);
        cpu(VAL, 0);
        status(1, s);
        chk("R7 ctrl IN validated", s, xs(1, 1, 1, 0, 0, 0));
        rx(0, 8, 1, 5, hs);
        hs_check("R8 setup ack while full", 2);
        status(1, s);
        chk("R8 IN flushed and locked", s, xs(0, 1, 1, 0, 1, 0));
        status(0, s);
        chk("R8 OUT setup held", s, xs(1, 1, 0, 1, 1, 1));
        cpu(RDL, 0);
        chk("R8 setup length", int'(cpu_rdata), 8);
        cpu(RDB, 0);
        chk("R8 setup data", int'(cpu_rdata), int'(pat(0, 0, 5)));
        txq(1, hs, ln);
        hs_check("R8 nothing to send", 1);
        cpu(CLR, 0);
        cpu(STAT, 0);
        chk("R9 clear ignored", int'(cpu_rdata), xs(1, 1, 0, 1, 1, 0));
        cpu(SEL, 1);
        cpu(VAL, 0);
        cpu(STAT, 0);
        chk("R9 validate ignored", int'(cpu_rdata), xs(0, 1, 1, 0, 1, 0));
        cpu(SEL, 0);
        cpu(ACKS, 0);
        cpu(STAT, 0);
        chk("R10 OUT unlocked", int'(cpu_rdata), xs(1, 1, 0, 1, 0, 0));
        status(1, s);
        chk("R10 IN still locked", s, xs(0, 1, 1, 0, 1, 0));
        cpu(SEL, 0);
        cpu(CLR, 0);
        cpu(STAT, 0);
        chk("R10 OUT clear works", int'(cpu_rdata), xs(0, 1, 0, 0, 0, 0));
        cpu(SEL, 1);
        cpu(ACKS, 0);
        cpu(VAL, 0);
        txq(1, hs, ln);
        chk("R10 IN length kept", ln, 2);
        hs_check("R10 IN sends after ack", 2);
        sent(1);

        // R4: event wins over same-cycle status read
        status(2, s);
        cpu(SEL, 2);
        @(negedge clk);
        cpu_stb = 1'b1; cpu_op = STAT;
        eng_rx_stb = 1'b1; eng_rx_setup = 1'b0; eng_rx_ep = 4'd2; eng_rx_len = 7'd1;
        @(negedge clk);
        cpu_stb = 1'b0; eng_rx_stb = 1'b0;
        chk("R4 read returns pre-event", int'(cpu_rdata), xs(0, 1, 0, 0, 0, 0));
        chk("R4 irq set wins", int'(ep_irq[2]), 1);
        chk("R4 irq_any", int'(irq_any), 1);
        hs_check("R2 same-cycle rx ack", 2);

        // R11: configuration of control slots ignored, disable works
        cpu(SEL, 0);
        cpu(CFG, 0);
        cpu(STAT, 0);
        chk("R11 ctrl config ignored", int'(cpu_rdata), xs(0, 1, 0, 0, 0, 0));
        status(1, s);
        chk("R11 ctrl IN fixed", s, xs(0, 1, 1, 0, 0, 1));
        cpu(SEL, 4);
        cpu(CFG, 0);
        rx(4, 1, 0, 0, hs);
        hs_check("R3 disabled slot nak", 1);

        // R1: bus reset
        @(negedge clk);
        bus_rst = 1'b1;
        @(negedge clk);
        bus_rst = 1'b0;
        chk("R1 bus reset irq", int'(ep_irq), 0);
        status(2, s);
        chk("R1 bus reset slot 2", s, xs(0, 0, 0, 0, 0, 0));
        status(0, s);
        chk("R1 bus reset slot 0", s, xs(0, 1, 0, 0, 0, 0));
        rx(2, 1, 0, 0, hs);
        hs_check("R1 slot 2 disabled after bus reset", 1);

        summary();
    end

endmodule